// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block keeps the inter-processor interrupt state of one core and drives that core's interrupt line. Software reaches it through a 32-bit register port. Each access is a single strobe and gets its response one clock later. Only the low eight bits of the access address select a register. The bank holds four kinds of state:

- a read-only pending word;
- an enable word;
- two write-only strobe registers, one that adds pending bits and one that removes them;
- a small mailbox of 32-bit words that other cores use to pass arguments.

A separate doorbell input lets a sender raise one pending bit, chosen by a vector number. It acts exactly as a write of that single bit to the add strobe.

The interrupt output is a registered level, and only strobe events move it. It rises when an add event leaves a pending bit that is also enabled. It falls only when a remove event leaves the whole pending word empty while the enable word is nonzero. Clearing every enabled pending bit does not lower the line while other pending bits remain. Writing the enable word never moves the line by itself. Accesses to offsets that the bank does not decode read as zero and change nothing. Such accesses, and writes to the read-only pending word, each produce a one-cycle event pulse.

Top module: `ipi_core_bank`

## Requirements
- R1: Only address bits [7:0] select a register, and higher address bits are ignored. Word offsets are: pending 0x00, enable 0x04, add strobe 0x08, remove strobe 0x0C.
- R2: A write to the pending word (0x00) leaves it unchanged and pulses `ro_write_evt` in the response cycle.
- R3: A write to the enable word (0x04) replaces all of its bits, and a read of 0x04 returns it.
- R4: A write to the add strobe (0x08) ORs the data into the pending word. The interrupt rises if the result ANDed with enable is nonzero.
- R5: A write to the remove strobe (0x0C) clears the written bits from the pending word. The interrupt falls only if the pending word is then zero and enable is nonzero; otherwise it keeps its level.
- R6: Reads of 0x08 and 0x0C always return zero.
- R7: Eight mailbox words sit at offsets 0x20, 0x24, … 0x3C. Word k is at offset 0x20 + 4·k, and each word reads back what was last written to it.
- R8: Any other offset, including offsets that are not multiples of 4, reads as zero. Writes to it change no state, and the access pulses `unimpl_evt` in the response cycle.
- R9: `db_valid` with `db_vector` = v sets pending bit v under the rule of R4. When a remove-strobe write lands in the same cycle, the doorbell bit is added first and then the remove applies.
- R10: Reset clears the pending word, enable, every mailbox word and the interrupt output.
- R11: `rsp_valid`, `rsp_rdata` and the event pulses appear on the clock edge that follows the access. `rsp_valid` is low when no access was made.
- R12: The interrupt output changes only on an add, doorbell or remove event. Writing enable does not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe for one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits [7:0] decoded |
| req_wdata | input | DATA_W | Write data |
| db_valid | input | 1 | Doorbell: set one pending bit |
| db_vector | input | VEC_W | Pending bit number for the doorbell |
| rsp_valid | output | 1 | Response for last cycle's access |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| ro_write_evt | output | 1 | Pulse: write to the read-only pending word |
| unimpl_evt | output | 1 | Pulse: access to an undecoded offset |
| irq | output | 1 | Interrupt level for the core |

## Verification
The bench builds the bank with a 12-bit address, 32-bit data and eight mailbox words, so the same register can be reached through aliases whose upper address bits differ. The full 5-bit vector range lets a doorbell reach bit 31. The eight words fill the mailbox window exactly, which makes the last word at 0x3C and the first undecoded offset at 0x40 meaningful boundaries. The interrupt sequences cover the cases where the masked pending word goes empty while other bits stay pending, and where enable is zero when the last bit is removed; in both the line must hold its level.

// File: rtl/ipi_core_bank.sv
module ipi_core_bank #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 32,
  parameter int VEC_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              db_valid,
  input  logic [VEC_W-1:0]  db_vector,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ro_write_evt,
  output logic              unimpl_evt,
  output logic              irq
);
  localparam int OFF_W   = 8;
  localparam int IDX_W   = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
  localparam int MBOX_END = MBOX_BASE + 4 * MBOX_WORDS;
  localparam logic [OFF_W-1:0] OFF_PEND = 8'h00;
  localparam logic [OFF_W-1:0] OFF_EN   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_ADD  = 8'h08;
  localparam logic [OFF_W-1:0] OFF_REM  = 8'h0C;

  logic [OFF_W-1:0]  off;
  logic [OFF_W:0]    mb_rel;
  logic [IDX_W-1:0]  mb_idx;
  logic              hit_pend, hit_en, hit_add, hit_rem, hit_mbox, hit_any;
  logic              wr, rd;
  logic              add_ev, rem_ev;
  logic [DATA_W-1:0] add_bits, rem_bits, pend_nx;
  logic [DATA_W-1:0] pend_q, en_q;
  logic [DATA_W-1:0] mbox_q [MBOX_WORDS];
  logic [DATA_W-1:0] rd_mux;
  logic              irq_nx;

  assign off      = req_addr[OFF_W-1:0];
  assign mb_rel   = {1'b0, off} - (OFF_W+1)'(MBOX_BASE);
  assign mb_idx   = mb_rel[IDX_W+1:2];
  assign hit_pend = (off == OFF_PEND);
  assign hit_en   = (off == OFF_EN);
  assign hit_add  = (off == OFF_ADD);
  assign hit_rem  = (off == OFF_REM);
  assign hit_mbox = ({1'b0, off} >= (OFF_W+1)'(MBOX_BASE)) &&
                    ({1'b0, off} <  (OFF_W+1)'(MBOX_END)) && (off[1:0] == 2'b00);
  assign hit_any  = hit_pend | hit_en | hit_add | hit_rem | hit_mbox;

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  assign add_ev   = (wr & hit_add) | db_valid;
  assign rem_ev   = wr & hit_rem;
  assign add_bits = ((wr & hit_add) ? req_wdata : '0) |
                    (db_valid ? (DATA_W'(1) << db_vector) : '0);
  assign rem_bits = rem_ev ? req_wdata : '0;
  assign pend_nx  = (pend_q | add_bits) & ~rem_bits;

  always_comb begin
    irq_nx = irq;
    if (rem_ev && pend_nx == '0 && en_q != '0)
      irq_nx = 1'b0;
    else if (add_ev && (pend_nx & en_q) != '0)
      irq_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_nx;
      irq    <= irq_nx;
      if (wr && hit_en) en_q <= req_wdata;
    end
  end

  for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_mbox
    always_ff @(posedge clk) begin
      if (!rst_n)
        mbox_q[g] <= '0;
      else if (wr && hit_mbox && mb_idx == IDX_W'(g))
        mbox_q[g] <= req_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_pend)      rd_mux = pend_q;
    else if (hit_en)   rd_mux = en_q;
    else if (hit_mbox) rd_mux = mbox_q[mb_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      ro_write_evt <= 1'b0;
      unimpl_evt   <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_rdata    <= rd ? rd_mux : '0;
      ro_write_evt <= wr & hit_pend;
      unimpl_evt   <= req_valid & ~hit_any;
    end
  end
endmodule

// File: rtl/ipi_core_bank_chk.sv
module ipi_core_bank_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              db_valid,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              ro_write_evt,
  input logic              unimpl_evt,
  input logic              irq,
  input logic [DATA_W-1:0] pend,
  input logic [DATA_W-1:0] en
);
  logic wr_pend, wr_en, wr_add, wr_rem, rd_strobe;
  assign wr_pend   = req_valid && req_write && req_addr[7:0] == 8'h00;
  assign wr_en     = req_valid && req_write && req_addr[7:0] == 8'h04;
  assign wr_add    = req_valid && req_write && req_addr[7:0] == 8'h08;
  assign wr_rem    = req_valid && req_write && req_addr[7:0] == 8'h0C;
  assign rd_strobe = req_valid && !req_write &&
                     (req_addr[7:0] == 8'h08 || req_addr[7:0] == 8'h0C);

  assert_ro_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ro_write_evt);
  assert_ro_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && !db_valid) |=> $stable(pend));
  assert_en_replace_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> en == $past(req_wdata));
  assert_raise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_add || db_valid) && (pend & en) != '0);
  assert_lower_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_rem) && pend == '0);
  assert_strobe_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rsp_rdata == '0);
  assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !unimpl_evt && !ro_write_evt);
  assert_irq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_add || wr_rem || db_valid) |=> $stable(irq));
endmodule

bind ipi_core_bank ipi_core_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .db_valid(db_valid),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ro_write_evt(ro_write_evt),
  .unimpl_evt(unimpl_evt), .irq(irq), .pend(pend_q), .en(en_q)
);

// File: tb/sim_ipi_core_bank.sv
module sim_ipi_core_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        db_valid = 1'b0;
  logic [4:0]  db_vector = '0;
  logic        rsp_valid, ro_write_evt, unimpl_evt, irq;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ipi_core_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .db_valid(db_valid),
    .db_vector(db_vector), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ro_write_evt(ro_write_evt), .unimpl_evt(unimpl_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input bit w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] rdat, output logic ro, output logic un);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R11", {31'b0, rsp_valid}, 32'd1);
    rdat = rsp_rdata; ro = ro_write_evt; un = unimpl_evt;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic ro, un;
    bus(1'b1, a, d, r, ro, un);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    logic ro, un;
    bus(1'b0, a, 32'h0, r, ro, un);
  endtask

  task automatic t_reset_r10();
    logic [31:0] r;
    chk("R10 irq", {31'b0, irq}, 32'd0);
    rd(12'h000, r); chk("R10 pending", r, 32'h0);
    rd(12'h004, r); chk("R10 enable", r, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(12'(32 + 4 * k), r); chk("R10 mailbox", r, 32'h0);
    end
    @(negedge clk);
    chk("R11 idle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_enable_r3();
    logic [31:0] r;
    wr(12'h004, 32'hFFFF_0000);
    wr(12'h004, 32'h0000_00A5);
    rd(12'h004, r); chk("R3", r, 32'h0000_00A5);
    wr(12'h004, 32'h0);
  endtask

  task automatic t_alias_r1();
    logic [31:0] r;
    wr(12'hF04, 32'h1234_5678);
    rd(12'h004, r); chk("R1 alias write", r, 32'h1234_5678);
    rd(12'hA04, r); chk("R1 alias read", r, 32'h1234_5678);
    wr(12'h004, 32'h0);
  endtask

  task automatic t_status_ro_r2();
    logic [31:0] r; logic ro, un;
    bus(1'b1, 12'h000, 32'hFFFF_FFFF, r, ro, un);
    chk("R2 event", {31'b0, ro}, 32'd1);
    chk("R2 no unimpl", {31'b0, un}, 32'd0);
    rd(12'h000, r); chk("R2 unchanged", r, 32'h0);
    chk("R2 irq", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_strobe_read_r6();
    logic [31:0] r;
    wr(12'h008, 32'h0000_0010);
    rd(12'h008, r); chk("R6 add reads zero", r, 32'h0);
    rd(12'h00C, r); chk("R6 remove reads zero", r, 32'h0);
    rd(12'h000, r); chk("R4 pending", r, 32'h0000_0010);
    wr(12'h00C, 32'h0000_0010);
  endtask

  task automatic t_set_clear_r4_r5();
    logic [31:0] r;
    wr(12'h004, 32'h1);
    wr(12'h008, 32'h3);
    chk("R4 raise", {31'b0, irq}, 32'd1);
    wr(12'h00C, 32'h1);
    rd(12'h000, r); chk("R5 bits removed", r, 32'h2);
    chk("R5 hold while pending", {31'b0, irq}, 32'd1);
    wr(12'h004, 32'h0);
    chk("R12 enable write keeps irq", {31'b0, irq}, 32'd1);
    wr(12'h00C, 32'h2);
    chk("R5 enable zero keeps irq", {31'b0, irq}, 32'd1);
    wr(12'h004, 32'h1);
    chk("R12 enable write keeps irq", {31'b0, irq}, 32'd1);
    wr(12'h00C, 32'h0);
    chk("R5 lower", {31'b0, irq}, 32'd0);
    wr(12'h008, 32'h4);
    chk("R4 masked no raise", {31'b0, irq}, 32'd0);
    wr(12'h004, 32'h4);
    chk("R12 enable no raise", {31'b0, irq}, 32'd0);
    wr(12'h008, 32'h0);
    chk("R4 raise on empty add", {31'b0, irq}, 32'd1);
    wr(12'h00C, 32'h4);
    chk("R5 lower all", {31'b0, irq}, 32'd0);
    wr(12'h004, 32'h0);
  endtask

  task automatic t_mailbox_r7();
    logic [31:0] r;
    for (int k = 0; k < 8; k++) wr(12'(32 + 4 * k), 32'hC0DE_0000 + 32'(k * 17));
    for (int k = 7; k >= 0; k--) begin
      rd(12'(32 + 4 * k), r); chk("R7 word", r, 32'hC0DE_0000 + 32'(k * 17));
    end
  endtask

  task automatic t_unimpl_r8();
    logic [31:0] r; logic ro, un;
    bus(1'b1, 12'h040, 32'hDEAD_BEEF, r, ro, un);
    chk("R8 event 0x40", {31'b0, un}, 32'd1);
    bus(1'b1, 12'h021, 32'hDEAD_BEEF, r, ro, un);
    chk("R8 event misaligned", {31'b0, un}, 32'd1);
    bus(1'b0, 12'h010, 32'h0, r, ro, un);
    chk("R8 read event", {31'b0, un}, 32'd1);
    chk("R8 read zero", r, 32'h0);
    bus(1'b0, 12'h005, 32'h0, r, ro, un);
    chk("R8 misaligned read zero", r, 32'h0);
    rd(12'h020, r); chk("R8 mailbox untouched", r, 32'hC0DE_0000);
    rd(12'h03C, r); chk("R8 last word untouched", r, 32'hC0DE_0000 + 32'd119);
    rd(12'h000, r); chk("R8 pending untouched", r, 32'h0);
  endtask

  task automatic t_doorbell_r9();
    logic [31:0] r;
    wr(12'h004, 32'h8000_0000);
    @(negedge clk); db_valid = 1'b1; db_vector = 5'd31;
    @(negedge clk); db_valid = 1'b0;
    chk("R9 raise bit 31", {31'b0, irq}, 32'd1);
    rd(12'h000, r); chk("R9 pending bit", r, 32'h8000_0000);
    @(negedge clk);
    db_valid = 1'b1; db_vector = 5'd3;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h00C; req_wdata = 32'h8000_0008;
    @(negedge clk);
    db_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    chk("R9 remove after add", {31'b0, irq}, 32'd0);
    rd(12'h000, r); chk("R9 pending empty", r, 32'h0);
    wr(12'h004, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r10();
    t_enable_r3();
    t_alias_r1();
    t_status_ro_r2();
    t_strobe_read_r6();
    t_set_clear_r4_r5();
    t_mailbox_r7();
    t_unimpl_r8();
    t_doorbell_r9();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule